// File: doc/BRIEF.md
# 128x32 Text-Mode Video Timing Generator

This block drives a 1024x576 raster from a 50 MHz pixel clock and turns it into a 128-column by 32-row text screen of 8x16 glyphs. It runs a horizontal counter and a vertical counter. From these it produces active-high sync pulses, a blanking flag, and the position of the current pixel within the text grid. It also issues the fetch addresses for the character RAM and the glyph ROM early enough that each glyph byte is ready when its cell begins.

The 512 text lines sit in the middle of the 576 visible lines. Two character rows of blank border lie above the text and two below it. The glyph ROM holds 32 fonts stored back to back, 4096 bytes per font, and a 5-bit font select picks which one is used. A glyph byte is shifted out with its most significant bit first. Every dimension and porch is a parameter, so a reduced configuration can be exercised in full.

Top module: `txtgen_top`

## Requirements
- R1: Each line lasts H_TOTAL clocks (default 1024 active + 8 front + 176 sync + 56 back = 1264). `hsync` is high exactly for horizontal positions H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1.
- R2: Each frame lasts V_TOTAL lines (default 576 + 1 + 3 + 17 = 597). `vsync` is high for the whole of lines V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1.
- R3: `blank` is low only when the horizontal position is below H_ACT and the line lies in the text band, from BORDER_ROWS*16 up to BORDER_ROWS*16+ROWS*16-1. This keeps the border lines and the porches blank.
- R4: While not blanked, `cell_col` = h/8, `cell_row` = (v-top)/16, `glyph_line` = (v-top)%16 and `pix_idx` = h%8. While blanked, all four are zero.
- R5: `pixel` carries bit (7 - `pix_idx`) of the glyph byte for the current cell and is zero while blanked.
- R6: When a position with h%8 = 4 is output, `text_addr` shows {row, column} of the cell that holds the position 4 clocks ahead, wrapping into the next line. The character RAM must return `char_code` one clock after the address.
- R7: When a position with h%8 = 6 is output, `glyph_addr` shows {font_sel[4:0], char_code[7:0], scanline[3:0]} for that same cell. The glyph ROM must return `glyph_byte` one clock after the address, and the byte is loaded on the cell's first pixel.
- R8: While `rst` is high: `hsync` = 0, `vsync` = 0, `blank` = 1, `pixel` = 0, and all position fields are zero. The first clock after reset outputs position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| font_sel | input | 5 | Font index, used as the upper glyph address bits |
| char_code | input | 8 | Character code from the text RAM |
| glyph_byte | input | 8 | Glyph row from the font ROM |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the visible text area |
| cell_col | output | 7 | Character column |
| cell_row | output | 5 | Character row |
| glyph_line | output | 4 | Scanline within the glyph |
| pix_idx | output | 3 | Pixel within the glyph |
| pixel | output | 1 | Foreground pixel |
| text_addr | output | 12 | Text RAM address {row, column} |
| glyph_addr | output | 17 | Font ROM address {font, code, scanline} |

## Verification
A reduced raster of 4 columns, 2 text rows and 1 border row on each side is swept position by position over three full frames. The frames use three different font selects, so a font bit that is lost or swapped shows up in both `glyph_addr` and the pixels. The bench RAM and ROM models return codes and bytes that differ per address. This exposes an address issued in the wrong cycle, or for the wrong cell, as a wrong pixel. The sweep also covers the line wrap, where the first cell of a line is fetched during the previous line's back porch. Border lines, both porches and both sync windows are compared at every position, which separates an off-by-one in the sync windows from a shifted text band.

// File: rtl/txtgen_pkg.sv
package txtgen_pkg;
  localparam int GLYPH_W    = 8;
  localparam int GLYPH_H    = 16;
  localparam int CODE_W     = 8;
  localparam int LINE_W     = 4;
  localparam int PIX_W      = 3;
  localparam int FONT_W     = 5;
  // clocks between the text address strobe and the start of the fetched cell
  localparam int FETCH_LEAD = 4;
endpackage

// File: rtl/txtgen_scan_counter.sv
module txtgen_scan_counter #(
  parameter int H_TOTAL = 1264,
  parameter int V_TOTAL = 597,
  parameter int HW      = 11,
  parameter int VW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_q,
  output logic [VW-1:0] v_q
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  // R1
  h_range_chk: assert property (@(posedge clk) disable iff (rst) h_q <= H_LAST);
  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q == H_LAST) |=> (h_q == '0));
  // R2
  v_range_chk: assert property (@(posedge clk) disable iff (rst) v_q <= V_LAST);
  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q != H_LAST) |=> $stable(v_q));
endmodule

// File: rtl/txtgen_sync_decode.sv
module txtgen_sync_decode
  import txtgen_pkg::*;
#(
  parameter int H_ACT      = 1024,
  parameter int H_FP       = 8,
  parameter int H_SYNC     = 176,
  parameter int V_ACT      = 576,
  parameter int V_FP       = 1,
  parameter int V_SYNC     = 3,
  parameter int TOP_LINES  = 32,
  parameter int TEXT_LINES = 512,
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int CW         = 7,
  parameter int RW         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     h_q,
  input  logic [VW-1:0]     v_q,
  output logic              hsync_q,
  output logic              vsync_q,
  output logic              blank_q,
  output logic [CW-1:0]     col_q,
  output logic [RW-1:0]     row_q,
  output logic [LINE_W-1:0] line_q,
  output logic [PIX_W-1:0]  pix_q
);
  localparam logic [HW-1:0] H_ACT_C = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [VW-1:0] V_TOP   = VW'(TOP_LINES);
  localparam logic [VW-1:0] V_BOT   = VW'(TOP_LINES + TEXT_LINES);

  logic          in_text;
  logic [VW-1:0] text_v;
  logic          unused_dec;

  assign in_text    = (h_q < H_ACT_C) && (v_q >= V_TOP) && (v_q < V_BOT);
  assign text_v     = v_q - V_TOP;
  assign unused_dec = ^text_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_q <= 1'b0;
      vsync_q <= 1'b0;
      blank_q <= 1'b1;
      col_q   <= '0;
      row_q   <= '0;
      line_q  <= '0;
      pix_q   <= '0;
    end else begin
      hsync_q <= (h_q >= HS_BEG) && (h_q < HS_END);
      vsync_q <= (v_q >= VS_BEG) && (v_q < VS_END);
      blank_q <= !in_text;
      if (in_text) begin
        col_q  <= h_q[CW+2:3];
        row_q  <= text_v[RW+3:4];
        line_q <= text_v[3:0];
        pix_q  <= h_q[2:0];
      end else begin
        col_q  <= '0;
        row_q  <= '0;
        line_q <= '0;
        pix_q  <= '0;
      end
    end
  end

  // R1
  hsync_blank_chk: assert property (@(posedge clk) disable iff (rst) hsync_q |-> blank_q);
  // R2
  vsync_blank_chk: assert property (@(posedge clk) disable iff (rst) vsync_q |-> blank_q);
  // R4
  idle_fields_chk: assert property (@(posedge clk) disable iff (rst)
    blank_q |-> (col_q == '0 && row_q == '0 && line_q == '0 && pix_q == '0));
  // R4
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_q && pix_q != 3'd7) |=> (blank_q || pix_q == $past(pix_q) + 3'd1));
endmodule

// File: rtl/txtgen_glyph_fetch.sv
module txtgen_glyph_fetch
  import txtgen_pkg::*;
#(
  parameter int H_TOTAL   = 1264,
  parameter int V_TOTAL   = 597,
  parameter int TOP_LINES = 32,
  parameter int HW        = 11,
  parameter int VW        = 10,
  parameter int CW        = 7,
  parameter int RW        = 5,
  parameter int GAW       = FONT_W + CODE_W + LINE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HW-1:0]      h_q,
  input  logic [VW-1:0]      v_q,
  input  logic [FONT_W-1:0]  font_sel,
  input  logic [CODE_W-1:0]  char_code,
  input  logic [GLYPH_W-1:0] glyph_byte,
  output logic [RW+CW-1:0]   text_addr_q,
  output logic [GAW-1:0]     glyph_addr_q,
  output logic               shift_msb
);
  localparam logic [HW-1:0]    H_WRAP   = HW'(H_TOTAL - FETCH_LEAD);
  localparam logic [HW-1:0]    LEAD_C   = HW'(FETCH_LEAD);
  localparam logic [VW-1:0]    V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0]    V_TOP    = VW'(TOP_LINES);
  localparam logic [PIX_W-1:0] LOAD_PH  = 3'd0;
  localparam logic [PIX_W-1:0] TADDR_PH = 3'(GLYPH_W - FETCH_LEAD);
  localparam logic [PIX_W-1:0] GADDR_PH = 3'(GLYPH_W - FETCH_LEAD + 2);

  logic [HW-1:0]      look_h;
  logic [VW-1:0]      look_v;
  logic [VW-1:0]      text_v;
  logic [LINE_W-1:0]  line_hold_q;
  logic [GLYPH_W-1:0] shreg_q;
  logic               unused_fetch;

  // position FETCH_LEAD clocks ahead, carried into the next line at its end
  always_comb begin
    if (h_q >= H_WRAP) begin
      look_h = h_q - H_WRAP;
      look_v = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      look_h = h_q + LEAD_C;
      look_v = v_q;
    end
  end

  assign text_v       = look_v - V_TOP;
  assign unused_fetch = ^{look_h, text_v};

  always_ff @(posedge clk) begin
    if (rst) begin
      text_addr_q  <= '0;
      line_hold_q  <= '0;
      glyph_addr_q <= '0;
      shreg_q      <= '0;
    end else begin
      if (h_q[2:0] == TADDR_PH) begin
        text_addr_q <= {text_v[RW+3:4], look_h[CW+2:3]};
        line_hold_q <= text_v[3:0];
      end
      if (h_q[2:0] == GADDR_PH)
        glyph_addr_q <= {font_sel, char_code, line_hold_q};
      if (h_q[2:0] == LOAD_PH)
        shreg_q <= glyph_byte;
      else
        shreg_q <= {shreg_q[GLYPH_W-2:0], 1'b0};
    end
  end

  assign shift_msb = shreg_q[GLYPH_W-1];

  // R6
  taddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q[2:0] != TADDR_PH) |=> $stable(text_addr_q));
  // R7
  gaddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q[2:0] != GADDR_PH) |=> $stable(glyph_addr_q));
endmodule

// File: rtl/txtgen_top.sv
module txtgen_top
  import txtgen_pkg::*;
#(
  parameter int COLS        = 128,
  parameter int ROWS        = 32,
  parameter int BORDER_ROWS = 2,
  parameter int H_FP        = 8,
  parameter int H_SYNC      = 176,
  parameter int H_BP        = 56,
  parameter int V_FP        = 1,
  parameter int V_SYNC      = 3,
  parameter int V_BP        = 17,
  localparam int CW         = $clog2(COLS),
  localparam int RW         = $clog2(ROWS),
  localparam int GAW        = FONT_W + CODE_W + LINE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FONT_W-1:0]  font_sel,
  input  logic [CODE_W-1:0]  char_code,
  input  logic [GLYPH_W-1:0] glyph_byte,
  output logic               hsync,
  output logic               vsync,
  output logic               blank,
  output logic [CW-1:0]      cell_col,
  output logic [RW-1:0]      cell_row,
  output logic [LINE_W-1:0]  glyph_line,
  output logic [PIX_W-1:0]   pix_idx,
  output logic               pixel,
  output logic [RW+CW-1:0]   text_addr,
  output logic [GAW-1:0]     glyph_addr
);
  localparam int H_ACT      = COLS * GLYPH_W;
  localparam int TOP_LINES  = BORDER_ROWS * GLYPH_H;
  localparam int TEXT_LINES = ROWS * GLYPH_H;
  localparam int V_ACT      = TEXT_LINES + 2 * TOP_LINES;
  localparam int H_TOTAL    = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL    = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW         = $clog2(H_TOTAL);
  localparam int VW         = $clog2(V_TOTAL);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          shift_msb;

  txtgen_scan_counter #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_cnt (
    .clk(clk), .rst(rst), .h_q(h_q), .v_q(v_q)
  );

  txtgen_sync_decode #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC),
    .TOP_LINES(TOP_LINES), .TEXT_LINES(TEXT_LINES),
    .HW(HW), .VW(VW), .CW(CW), .RW(RW)
  ) u_dec (
    .clk(clk), .rst(rst), .h_q(h_q), .v_q(v_q),
    .hsync_q(hsync), .vsync_q(vsync), .blank_q(blank),
    .col_q(cell_col), .row_q(cell_row), .line_q(glyph_line), .pix_q(pix_idx)
  );

  txtgen_glyph_fetch #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .TOP_LINES(TOP_LINES),
    .HW(HW), .VW(VW), .CW(CW), .RW(RW), .GAW(GAW)
  ) u_fetch (
    .clk(clk), .rst(rst), .h_q(h_q), .v_q(v_q),
    .font_sel(font_sel), .char_code(char_code), .glyph_byte(glyph_byte),
    .text_addr_q(text_addr), .glyph_addr_q(glyph_addr), .shift_msb(shift_msb)
  );

  assign pixel = shift_msb & ~blank;

  // R5
  pixel_blank_chk: assert property (@(posedge clk) disable iff (rst) blank |-> !pixel);
endmodule

// File: tb/txtgen_top_tb.sv
`timescale 1ns/1ps
module txtgen_top_tb;
  localparam int COLS = 4, ROWS = 2, BR = 1;
  localparam int HF = 8, HS = 8, HB = 8, VF = 1, VS = 3, VB = 2;
  localparam int HA = COLS * 8, TOP = BR * 16, BOT = TOP + ROWS * 16;
  localparam int VA = BOT + TOP;
  localparam int HT = HA + HF + HS + HB, VT = VA + VF + VS + VB;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] font_sel = 5'd0;
  logic [7:0] char_code = 8'd0, glyph_byte = 8'd0;
  logic hsync, vsync, blank, pixel;
  logic [1:0] cell_col;
  logic       cell_row;
  logic [3:0] glyph_line;
  logic [2:0] pix_idx;
  logic [2:0] text_addr;
  logic [16:0] glyph_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txtgen_top #(
    .COLS(COLS), .ROWS(ROWS), .BORDER_ROWS(BR),
    .H_FP(HF), .H_SYNC(HS), .H_BP(HB), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u_dut (
    .clk(clk), .rst(rst), .font_sel(font_sel), .char_code(char_code),
    .glyph_byte(glyph_byte), .hsync(hsync), .vsync(vsync), .blank(blank),
    .cell_col(cell_col), .cell_row(cell_row), .glyph_line(glyph_line),
    .pix_idx(pix_idx), .pixel(pixel), .text_addr(text_addr), .glyph_addr(glyph_addr)
  );

  function automatic int code_of(int a);
    return (a * 37 + 11) & 255;
  endfunction
  function automatic int byte_of(int a);
    return ((a * 13) ^ (a >> 7) ^ ((a >> 12) * 91)) & 255;
  endfunction

  // one-clock-latency memory models (R6, R7 contract)
  always_ff @(posedge clk) begin
    char_code  <= 8'(code_of(int'(text_addr)));
    glyph_byte <= 8'(byte_of(int'(glyph_addr)));
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pos(int h, int v, int font);
    bit act;
    int col, row, ln, px, cd, gb, lh, lv;
    act = (h < HA) && (v >= TOP) && (v < BOT);
    chk("R1 hsync", int'(hsync), int'(h >= HA + HF && h < HA + HF + HS));
    chk("R2 vsync", int'(vsync), int'(v >= VA + VF && v < VA + VF + VS));
    chk("R3 blank", int'(blank), int'(!act));
    col = act ? h / 8 : 0;
    row = act ? (v - TOP) / 16 : 0;
    ln  = act ? (v - TOP) % 16 : 0;
    px  = act ? h % 8 : 0;
    chk("R4 col", int'(cell_col), col);
    chk("R4 row", int'(cell_row), row);
    chk("R4 line", int'(glyph_line), ln);
    chk("R4 pix", int'(pix_idx), px);
    if (act) begin
      cd = code_of(row * COLS + col);
      gb = byte_of((font << 12) | (cd << 4) | ln);
      chk("R5 pixel", int'(pixel), (gb >> (7 - px)) & 1);
    end else begin
      chk("R5 pixel blank", int'(pixel), 0);
    end
    if (h % 8 == 4 || h % 8 == 6) begin
      lh = (h % 8 == 4) ? h + 4 : h + 2;
      lv = v;
      if (lh >= HT) begin lh -= HT; lv = (v + 1) % VT; end
      if (lh < HA && lv >= TOP && lv < BOT) begin
        cd = ((lv - TOP) / 16) * COLS + lh / 8;
        if (h % 8 == 4)
          chk("R6 text_addr", int'(text_addr), cd);
        else
          chk("R7 glyph_addr", int'(glyph_addr),
              (font << 12) | (code_of(cd) << 4) | ((lv - TOP) % 16));
      end
    end
  endtask

  initial begin
    int fonts[3] = '{0, 31, 9};
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 hsync", int'(hsync), 0);
    chk("R8 vsync", int'(vsync), 0);
    chk("R8 blank", int'(blank), 1);
    chk("R8 pixel", int'(pixel), 0);
    chk("R8 col", int'(cell_col), 0);
    rst = 1'b0;
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < VT; v++) begin
        for (int h = 0; h < HT; h++) begin
          if (h == 0 && v == 0) font_sel = 5'(fonts[f]);
          @(posedge clk);
          @(negedge clk);
          check_pos(h, v, fonts[f]);
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule